// File: doc/BRIEF.md
# Majority-Vote History Branch Predictor

This block predicts the direction of a conditional branch from that branch's own recent behaviour. Each table entry is a short shift register holding the resolved outcomes of the last few executions that mapped to it. The prediction for an entry is the majority of those stored outcomes. With three outcomes stored, the block predicts taken when at least two of them were taken.

A fetch stage presents the low bits of a branch address on the lookup port. The prediction comes back combinationally in the same cycle. When the branch resolves, the execute stage presents the same index and the actual outcome on the update port. That outcome enters the entry at the next clock edge. The table has no tags, so branches that share low address bits share one entry.

A history length of zero builds no table. The prediction is then a fixed direction chosen by parameter.

Top module: `maj_branch_pred`

## Requirements
- R1: While rst_ni is low, and on leaving reset, every entry holds all not-taken outcomes, so every lookup returns 0 (not taken).
- R2: lkp_taken_o is 1 exactly when at least (HIST_N+1)/2 of the HIST_N outcomes stored in entry lkp_idx_i are taken (1). With HIST_N = 3 this means two or more of three.
- R3: A clock edge with upd_valid_i high shifts upd_taken_i (1 = taken) into bit 0 of entry upd_idx_i. Older bits move one place up and the bit at position HIST_N-1 is discarded, so after HIST_N updates no earlier outcome affects the vote.
- R4: A clock edge with upd_valid_i low changes no entry, whatever upd_idx_i and upd_taken_i carry.
- R5: When a lookup and an update name the same entry in the same cycle, lkp_taken_o reflects the history before that update. The new outcome is seen from the next cycle on.
- R6: An update writes only the entry it names. A lookup reads only the entry it names, and its result follows a change of lkp_idx_i within the same cycle.
- R7: The table has 2^IDX_W entries addressed directly by the index. Entries 0 and 2^IDX_W-1 are distinct and fully usable.
- R8: With HIST_N = 0 no history is kept, and lkp_taken_o equals the STATIC_TAKEN parameter for every lookup and every update pattern.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lkp_idx_i | input | IDX_W | Index of the entry to predict from |
| lkp_taken_o | output | 1 | Predicted direction, 1 = taken |
| upd_valid_i | input | 1 | A resolved outcome is presented |
| upd_idx_i | input | IDX_W | Index of the entry to update |
| upd_taken_i | input | 1 | Resolved outcome, 1 = taken |

## Verification
A lookup and an update can both hit the same entry in one cycle. The bench provokes this by holding lkp_idx_i equal to upd_idx_i over runs of consecutive updates. It samples lkp_taken_o just before each rising edge, when the result must still come from the old history, and samples again after the edge. The sequences are chosen so that the vote flips exactly on the update that crosses the majority threshold. A flip that appears one cycle early, or one that never appears, is therefore reported.

// File: rtl/mvp_pkg.sv
package mvp_pkg;
  localparam int unsigned MAX_HIST = 7;

  // number of taken outcomes needed for a taken vote
  function automatic int unsigned vote_thresh(input int unsigned n);
    return (n + 1) / 2;
  endfunction
endpackage

// File: rtl/mvp_wr_decode.sv
module mvp_wr_decode #(
  parameter int unsigned IDX_W   = 4,
  localparam int unsigned ENTRIES = 1 << IDX_W
) (
  input  logic               en_i,
  input  logic [IDX_W-1:0]   idx_i,
  output logic [ENTRIES-1:0] we_o
);
  for (genvar e = 0; e < ENTRIES; e++) begin : g_dec
    assign we_o[e] = en_i && (idx_i == IDX_W'(e));
  end
endmodule

// File: rtl/mvp_hist_entry.sv
module mvp_hist_entry #(
  parameter int unsigned HW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic          bit_i,
  output logic [HW-1:0] q_o
);
  logic [HW-1:0] d;

  if (HW == 1) begin : g_one
    assign d = bit_i;
  end else begin : g_shift
    assign d = {q_o[HW-2:0], bit_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= d;
  end
endmodule

// File: rtl/mvp_majority.sv
module mvp_majority
  import mvp_pkg::*;
#(
  parameter int unsigned HW = 3,
  localparam int unsigned CNT_W = $clog2(HW + 1),
  localparam int unsigned THR   = vote_thresh(HW)
) (
  input  logic [HW-1:0] hist_i,
  output logic          vote_o
);
  logic [CNT_W-1:0] cnt;

  always_comb begin
    cnt = '0;
    for (int i = 0; i < HW; i++) cnt = cnt + CNT_W'(hist_i[i]);
  end

  assign vote_o = (cnt >= CNT_W'(THR));
endmodule

// File: rtl/maj_branch_pred.sv
module maj_branch_pred #(
  parameter int unsigned IDX_W        = 4,
  parameter int unsigned HIST_N       = 3,
  parameter bit          STATIC_TAKEN = 1'b0,
  localparam int unsigned ENTRIES = 1 << IDX_W,
  localparam int unsigned HW      = (HIST_N == 0) ? 1 : HIST_N
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] lkp_idx_i,
  output logic             lkp_taken_o,
  input  logic             upd_valid_i,
  input  logic [IDX_W-1:0] upd_idx_i,
  input  logic             upd_taken_i
);
  logic [ENTRIES*HW-1:0] hist_flat;

  if (HIST_N > 0) begin : g_dyn
    logic [ENTRIES-1:0] we;
    logic [HW-1:0]      rd_hist;

    mvp_wr_decode #(.IDX_W(IDX_W)) u_dec (
      .en_i  (upd_valid_i),
      .idx_i (upd_idx_i),
      .we_o  (we)
    );

    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
      mvp_hist_entry #(.HW(HW)) u_ent (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .we_i   (we[e]),
        .bit_i  (upd_taken_i),
        .q_o    (hist_flat[e*HW +: HW])
      );
    end

    // registered table: same-cycle lookup sees pre-update history
    assign rd_hist = hist_flat[lkp_idx_i*HW +: HW];

    mvp_majority #(.HW(HW)) u_vote (
      .hist_i (rd_hist),
      .vote_o (lkp_taken_o)
    );
  end else begin : g_static
    assign hist_flat   = '0;
    assign lkp_taken_o = STATIC_TAKEN;
  end
endmodule

// File: rtl/mvp_checker.sv
module mvp_checker #(
  parameter int unsigned IDX_W  = 4,
  parameter int unsigned HIST_N = 3,
  parameter int unsigned HW     = 3,
  localparam int unsigned ENTRIES = 1 << IDX_W
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [IDX_W-1:0]      lkp_idx_i,
  input logic                  lkp_taken_o,
  input logic                  upd_valid_i,
  input logic [IDX_W-1:0]      upd_idx_i,
  input logic                  upd_taken_i,
  input logic [ENTRIES*HW-1:0] hist_flat
);
  if (HIST_N > 0) begin : g_chk
    AST_RESET_CLEAR: assert property (@(posedge clk_i)
      $rose(rst_ni) |-> (hist_flat == '0)); // R1

    AST_ALL_TAKEN_VOTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($countones(hist_flat[lkp_idx_i*HW +: HW]) == HIST_N) |-> lkp_taken_o); // R2

    AST_NONE_TAKEN_VOTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($countones(hist_flat[lkp_idx_i*HW +: HW]) == 0) |-> !lkp_taken_o); // R2

    AST_NEW_BIT_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      upd_valid_i |=> (hist_flat[$past(upd_idx_i)*HW] == $past(upd_taken_i))); // R3

    if (HW > 1) begin : g_sh
      AST_SHIFT_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        upd_valid_i |=> (hist_flat[$past(upd_idx_i)*HW + 1] ==
                         $past(hist_flat[upd_idx_i*HW]))); // R3
    end

    AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !upd_valid_i |=> $stable(hist_flat)); // R4

    AST_PRED_NO_EARLY_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($stable(lkp_idx_i) && !$past(upd_valid_i)) |-> $stable(lkp_taken_o)); // R5
  end
endmodule

bind maj_branch_pred mvp_checker #(
  .IDX_W (IDX_W),
  .HIST_N(HIST_N),
  .HW    (HW)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .lkp_idx_i   (lkp_idx_i),
  .lkp_taken_o (lkp_taken_o),
  .upd_valid_i (upd_valid_i),
  .upd_idx_i   (upd_idx_i),
  .upd_taken_i (upd_taken_i),
  .hist_flat   (hist_flat)
);

// File: tb/maj_branch_pred_tb.sv
module maj_branch_pred_tb;
  localparam int CLK_PERIOD = 10;
  localparam int IDX_W      = 4;
  localparam int ENTRIES    = 1 << IDX_W;
  localparam int WATCHDOG   = 5000;
  localparam int NV         = 22;

  typedef struct packed {
    logic       uv;
    logic [3:0] ui;
    logic       ut;
    logic [3:0] li;
    logic       ep;
    logic [3:0] rq;
  } vec_t;

  // expected prediction is sampled before the edge that applies the vector's update
  localparam vec_t VECS [NV] = '{
    '{1'b1, 4'd3,  1'b1, 4'd3,  1'b0, 4'd1}, // R1 fresh entry 000
    '{1'b1, 4'd3,  1'b1, 4'd3,  1'b0, 4'd2}, // 001
    '{1'b0, 4'd3,  1'b0, 4'd3,  1'b1, 4'd2}, // 011 -> taken
    '{1'b1, 4'd3,  1'b0, 4'd3,  1'b1, 4'd5}, // R5 same-cycle sees 011
    '{1'b1, 4'd3,  1'b0, 4'd3,  1'b1, 4'd3}, // 110
    '{1'b0, 4'd0,  1'b0, 4'd3,  1'b0, 4'd3}, // 100
    '{1'b1, 4'd3,  1'b0, 4'd5,  1'b0, 4'd6}, // R6 other entry
    '{1'b1, 4'd0,  1'b1, 4'd3,  1'b0, 4'd3}, // 000
    '{1'b1, 4'd15, 1'b1, 4'd0,  1'b0, 4'd7}, // R7 entry 0 = 001
    '{1'b1, 4'd15, 1'b1, 4'd0,  1'b0, 4'd6}, // entry 0 unaffected
    '{1'b1, 4'd0,  1'b1, 4'd15, 1'b1, 4'd7}, // R7 entry 15 = 011
    '{1'b0, 4'd0,  1'b0, 4'd0,  1'b1, 4'd2}, // entry 0 = 011
    '{1'b0, 4'd0,  1'b0, 4'd0,  1'b1, 4'd4}, // R4 invalid update ignored
    '{1'b1, 4'd0,  1'b1, 4'd0,  1'b1, 4'd5}, // -> 111
    '{1'b1, 4'd0,  1'b0, 4'd0,  1'b1, 4'd2}, // 111
    '{1'b1, 4'd0,  1'b0, 4'd0,  1'b1, 4'd3}, // 110
    '{1'b1, 4'd0,  1'b0, 4'd0,  1'b0, 4'd3}, // 100
    '{1'b0, 4'd0,  1'b0, 4'd0,  1'b0, 4'd3}, // R3 000 takens flushed
    '{1'b1, 4'd7,  1'b1, 4'd7,  1'b0, 4'd2}, // 000
    '{1'b1, 4'd7,  1'b0, 4'd7,  1'b0, 4'd2}, // 001
    '{1'b1, 4'd7,  1'b1, 4'd7,  1'b0, 4'd5}, // 010
    '{1'b0, 4'd7,  1'b0, 4'd7,  1'b1, 4'd2}  // 101 -> taken
  };

  logic             clk;
  logic             rst_n;
  logic [IDX_W-1:0] lkp_idx;
  logic             lkp_taken;
  logic             lkp_taken_static;
  logic             upd_valid;
  logic [IDX_W-1:0] upd_idx;
  logic             upd_taken;

  int n_chk = 0;
  int n_err = 0;

  maj_branch_pred #(.IDX_W(IDX_W), .HIST_N(3)) u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .lkp_idx_i   (lkp_idx),
    .lkp_taken_o (lkp_taken),
    .upd_valid_i (upd_valid),
    .upd_idx_i   (upd_idx),
    .upd_taken_i (upd_taken)
  );

  maj_branch_pred #(.IDX_W(IDX_W), .HIST_N(0), .STATIC_TAKEN(1'b1)) u_dut_static (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .lkp_idx_i   (lkp_idx),
    .lkp_taken_o (lkp_taken_static),
    .upd_valid_i (upd_valid),
    .upd_idx_i   (upd_idx),
    .upd_taken_i (upd_taken)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input logic act, input logic exp, input int rq, input string what);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL R%0d %s: actual %0b expected %0b", rq, what, act, exp);
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired: actual running expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    rst_n = 1'b0; upd_valid = 1'b0; upd_idx = '0; upd_taken = 1'b0; lkp_idx = 4'd3;
    repeat (2) @(negedge clk);
    chk(lkp_taken, 1'b0, 1, "lookup during reset"); // R1
    rst_n = 1'b1;
    @(negedge clk);
    chk(lkp_taken, 1'b0, 1, "lookup after reset");

    for (int v = 0; v < NV; v++) begin
      upd_valid = VECS[v].uv;
      upd_idx   = VECS[v].ui;
      upd_taken = VECS[v].ut;
      lkp_idx   = VECS[v].li;
      #2;
      chk(lkp_taken, VECS[v].ep, int'(VECS[v].rq), $sformatf("vector %0d", v));
      chk(lkp_taken_static, 1'b1, 8, $sformatf("static vector %0d", v)); // R8
      @(negedge clk);
    end
    upd_valid = 1'b0;

    // R6: lookup follows a changed index within the cycle
    lkp_idx = 4'd15; #1;
    chk(lkp_taken, 1'b1, 6, "index 15 combinational");
    lkp_idx = 4'd3;  #1;
    chk(lkp_taken, 1'b0, 6, "index 3 combinational");
    lkp_idx = 4'd7;  #1;
    chk(lkp_taken, 1'b1, 6, "index 7 combinational");

    // R5: the update becomes visible right after its edge
    @(negedge clk);
    upd_valid = 1'b1; upd_idx = 4'd9; upd_taken = 1'b1; lkp_idx = 4'd9;
    @(negedge clk);
    chk(lkp_taken, 1'b0, 5, "one taken of three");
    @(posedge clk); #1;
    upd_valid = 1'b0;
    chk(lkp_taken, 1'b1, 5, "visible after second edge");

    // R1: asynchronous reset clears every entry
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    for (int e = 0; e < ENTRIES; e++) begin
      lkp_idx = IDX_W'(e);
      #1;
      chk(lkp_taken, 1'b0, 1, $sformatf("entry %0d after reset", e));
    end
    rst_n = 1'b1;
    @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule